// File: doc/BRIEF.md
# Programmable Glitch Pulse Generator

This block produces one active-high pulse per accepted fire strobe. The pulse is meant to close a crowbar switch across a supply rail, which briefly pulls the rail down to inject a voltage glitch. Two programmed values set the pulse length. A coarse count adds width in steps of three clock cycles. A 2-bit trim adds zero, one or two further cycles. Together they give single-cycle resolution across the whole range.

Each accepted fire first moves the generator into one fixed preparation cycle, and the pulse starts only after that cycle. Every pulse therefore begins from the same internal condition. Both settings are captured at the moment of the fire, so two fires with equal settings always give pulses of equal length. A busy flag covers the preparation cycle and the whole pulse. While busy is high, further fire strobes have no effect.

Top module: `glitch_pulse_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both `pulse_o` and `busy_o` are low.
- R2: A fire strobe sampled while `busy_o` is low raises `busy_o` one cycle later. `pulse_o` stays low for that one preparation cycle and rises in the cycle after it.
- R3: The pulse stays high for exactly 1 + 3*coarse + fine clock cycles, where coarse is `coarse_i` read as an unsigned number and fine is `fine_i` read as an unsigned 2-bit number.
- R4: With a coarse count of zero, the pulse lasts 1 + fine cycles, so its length is 1, 2 or 3 cycles.
- R5: A `fine_i` value of 3 gives the same width as a value of 2.
- R6: Each accepted fire produces exactly one pulse. `pulse_o` is high only while `busy_o` is high, and `busy_o` falls in the same cycle that `pulse_o` falls.
- R7: A fire strobe sampled while `busy_o` is high is ignored. It produces no extra pulse, and `busy_o` stays low once the current pulse ends.
- R8: `coarse_i` and `fine_i` are captured when a fire is accepted. Changing them later has no effect on the preparation cycle or the pulse already under way.
- R9: Repeated fires with the same settings produce pulses of identical width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| fire_i | input | 1 | Fire strobe, sampled on each rising clock edge |
| coarse_i | input | COARSE_W | Coarse width count, in units of three cycles |
| fine_i | input | 2 | Fine trim: 0, 1 or 2 extra cycles; 3 acts as 2 |
| pulse_o | output | 1 | Registered glitch pulse, active high |
| busy_o | output | 1 | High from the preparation cycle to the end of the pulse |

## Verification
A fire strobe sampled at clock edge k makes `busy_o` high from edge k+1. `pulse_o` rises at edge k+2 and stays high for the programmed width. `busy_o` falls at the same edge as `pulse_o`.

The bench drives inputs on falling edges and samples outputs on falling edges. Each output is read half a cycle after the edge that updated it. The driver checks the preparation cycle straight after the fire and pushes the expected width into a queue. The monitor measures each pulse and pops one queued width at every falling pulse edge. A pulse that arrives with no queued width shows up as an extra pulse.

// File: rtl/glitch_pkg.sv
package glitch_pkg;
  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_ARM  = 2'd1,
    GS_HIGH = 2'd2
  } gstate_e;

  localparam int unsigned FINE_W   = 2;
  localparam int unsigned FINE_MAX = 2;
  localparam int unsigned BASE_LEN = 1;
endpackage

// File: rtl/glitch_cfg_latch.sv
module glitch_cfg_latch
  import glitch_pkg::*;
#(
  parameter int unsigned COARSE_W = 8,
  parameter int unsigned CNT_W    = COARSE_W + 2
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                load_i,
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic [FINE_W-1:0]   fine_i,
  output logic [CNT_W-1:0]    width_o
);
  logic [FINE_W-1:0] fine_eff;
  logic [CNT_W-1:0]  coarse_x;
  logic [CNT_W-1:0]  width_d;
  logic [CNT_W-1:0]  width_q;

  // trim value 3 is clamped to the largest legal trim
  always_comb begin
    if (fine_i > FINE_W'(FINE_MAX)) fine_eff = FINE_W'(FINE_MAX);
    else                            fine_eff = fine_i;
  end

  always_comb begin
    coarse_x = CNT_W'(coarse_i);
    width_d  = CNT_W'(BASE_LEN) + (coarse_x << 1) + coarse_x + CNT_W'(fine_eff);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)       width_q <= CNT_W'(BASE_LEN);
    else if (load_i) width_q <= width_d;
  end

  assign width_o = width_q;

  assert_width_nonzero_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    width_q >= CNT_W'(BASE_LEN));
endmodule

// File: rtl/glitch_width_ctr.sv
module glitch_width_ctr #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)                          cnt_q <= '0;
    else if (start_i)                   cnt_q <= width_i - CNT_W'(1);
    else if (run_i && cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last_o = run_i && (cnt_q == '0);

  assert_count_below_width_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    run_i |-> (cnt_q < width_i));
endmodule

// File: rtl/glitch_seq.sv
module glitch_seq
  import glitch_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic fire_i,
  input  logic last_i,
  output logic load_o,
  output logic start_o,
  output logic run_o,
  output logic pulse_o,
  output logic busy_o
);
  gstate_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GS_IDLE: if (fire_i) state_d = GS_ARM;
      GS_ARM:              state_d = GS_HIGH;
      GS_HIGH: if (last_i) state_d = GS_IDLE;
      default:             state_d = GS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= GS_IDLE;
      pulse_o <= 1'b0;
      busy_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_o <= (state_d == GS_HIGH);
      busy_o  <= (state_d != GS_IDLE);
    end
  end

  assign load_o  = (state_q == GS_IDLE) && fire_i;
  assign start_o = (state_q == GS_ARM);
  assign run_o   = (state_q == GS_HIGH);

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    rst_i |=> (!pulse_o && !busy_o));

  assert_prep_before_pulse_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(pulse_o) |-> ($past(busy_o) && !$past(pulse_o)));

  assert_pulse_inside_busy_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_o |-> busy_o);

  assert_busy_ends_with_pulse_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(pulse_o) |-> !busy_o);
endmodule

// File: rtl/glitch_pulse_gen.sv
module glitch_pulse_gen
  import glitch_pkg::*;
#(
  parameter int unsigned COARSE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                fire_i,
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic [1:0]          fine_i,
  output logic                pulse_o,
  output logic                busy_o
);
  localparam int unsigned CNT_W = COARSE_W + 2;

  logic             load_w, start_w, run_w, last_w;
  logic [CNT_W-1:0] width_w;

  glitch_seq u_seq (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .fire_i  (fire_i),
    .last_i  (last_w),
    .load_o  (load_w),
    .start_o (start_w),
    .run_o   (run_w),
    .pulse_o (pulse_o),
    .busy_o  (busy_o)
  );

  glitch_cfg_latch #(.COARSE_W(COARSE_W), .CNT_W(CNT_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .load_i   (load_w),
    .coarse_i (coarse_i),
    .fine_i   (fine_i),
    .width_o  (width_w)
  );

  glitch_width_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (start_w),
    .run_i   (run_w),
    .width_i (width_w),
    .last_o  (last_w)
  );

  assert_cfg_frozen_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_o && $past(busy_o)) |-> $stable(width_w));
endmodule

// File: tb/test_glitch_pulse_gen.sv
module test_glitch_pulse_gen;
  localparam int unsigned CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fire = 1'b0;
  logic [CW-1:0] coarse = '0;
  logic [1:0]    fine = '0;
  logic          pulse, busy;

  int checks = 0;
  int fails  = 0;
  int exp_w[$];
  string exp_r[$];
  bit done = 0;

  always #10 clk = ~clk;

  glitch_pulse_gen #(.COARSE_W(CW)) i_glitch_pulse_gen (
    .clk_i(clk), .rst_i(rst), .fire_i(fire), .coarse_i(coarse),
    .fine_i(fine), .pulse_o(pulse), .busy_o(busy)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: measure each pulse and compare it with the scoreboard
  logic pulse_p = 1'b0, busy_p = 1'b0;
  int wcount = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (pulse && !pulse_p) check(busy_p && !pulse_p, "R2 prep cycle before pulse", int'(busy_p), 1);
      if (pulse) check(busy, "R6 pulse inside busy", int'(busy), 1);
      if (pulse) wcount++;
      if (!pulse && pulse_p) begin
        check(!busy, "R6 busy falls with pulse", int'(busy), 0);
        if (exp_w.size() == 0) check(0, "R7 unexpected extra pulse", wcount, 0);
        else begin
          int ew;
          string er;
          ew = exp_w.pop_front();
          er = exp_r.pop_front();
          check(wcount == ew, er, wcount, ew);
        end
        wcount = 0;
      end
    end
    pulse_p = pulse;
    busy_p  = busy;
  end

  function automatic int model_w(int c, int f);
    return 1 + 3 * c + ((f > 2) ? 2 : f);
  endfunction

  // driver: fire, check the prep cycle, push expectation
  task automatic fire_pulse(int c, int f, string req);
    @(negedge clk);
    coarse = CW'(c);
    fine   = 2'(f);
    fire   = 1'b1;
    exp_w.push_back(model_w(c, f));
    exp_r.push_back(req);
    @(negedge clk);
    fire = 1'b0;
    check(busy && !pulse, "R2 busy up, pulse low in prep", int'({busy, pulse}), 2);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!pulse && !busy, "R1 reset outputs", int'({pulse, busy}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!pulse && !busy, "R1 after reset", int'({pulse, busy}), 0);

    for (int f = 0; f < 4; f++) begin
      fire_pulse(0, f, (f == 3) ? "R5 trim 3 as 2" : "R4 coarse zero");
      wait_idle();
    end
    for (int c = 1; c < 6; c++) begin
      fire_pulse(c, c % 3, "R3 width formula");
      wait_idle();
    end
    fire_pulse(7, 3, "R5 trim 3 with coarse");
    wait_idle();
    fire_pulse(255, 2, "R3 max width");
    wait_idle();
    for (int k = 0; k < 3; k++) begin
      fire_pulse(4, 1, "R9 repeatable width");
      wait_idle();
    end

    // R8: change settings during the pulse
    fire_pulse(6, 0, "R8 settings latched");
    coarse = 8'd1;
    fine   = 2'd2;
    repeat (4) @(negedge clk);
    coarse = 8'd200;
    wait_idle();

    // R7: fire strobes during busy are ignored
    fire_pulse(3, 2, "R7 width unaffected");
    fire = 1'b1;
    @(negedge clk);
    fire = 1'b0;
    repeat (3) @(negedge clk);
    fire = 1'b1;
    @(negedge clk);
    fire = 1'b0;
    while (busy) begin
      fire = 1'b1;
      @(negedge clk);
    end
    fire = 1'b0;
    repeat (5) begin
      check(!busy && !pulse, "R7 no pulse from busy fire", int'({busy, pulse}), 0);
      @(negedge clk);
    end
    check(exp_w.size() == 0, "R6 one pulse per fire", exp_w.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule